// File: doc/BRIEF.md
# Bidirectional 12-bit Serial Transfer Register

This block moves a 12-bit word across a one-wire serial link in either direction. In transmit mode it places one bit of the parallel input word on the serial output at every rising clock edge, lowest bit first. It also drives an output-enable, so that a tri-state pad outside the block can share one wire for both directions. In receive mode it samples the serial input at every rising edge and fills the word from the lowest bit upward. After the twelfth bit in either direction, the matching completion flag is high for exactly one cycle.

Direction is chosen by two mode pins. The completion flags take part in the decode: while a flag is high, that direction is blocked for the cycle. This forces one idle cycle between back-to-back frames. The serial stream has no valid/ready handshake and no back-pressure. Every active edge moves one bit, so the source must hold the parallel word stable for the whole transmit frame. The sink must take the received word while it is presented, which is from the completion pulse until the next receive completes. Framing, start and stop bits, and parity are left to surrounding logic.

Top module: `serial_xfer_reg`

## Requirements
- R1: A synchronous active-high reset clears `tx_done`, `rx_done`, `ser_out`, `ser_oe` and `word_out` to 0 at the next rising edge, and these outputs read 0 after that edge.
- R2: Transmit is active in a cycle when `tx_mode`=1, `rx_mode`=0 and `tx_done`=0. After the k-th consecutive active edge (k = 1..12), `ser_out` equals `word_in[k-1]`, so bit 0 goes out first.
- R3: `tx_done` rises on the same edge that presents bit 11 and stays high for exactly one cycle. No bit is transferred in that cycle, and if transmit stays selected the next frame starts again at bit 0.
- R4: Receive is active in a cycle when `tx_mode`=0, `rx_mode`=1 and `rx_done`=0. The k-th active edge stores `ser_in` into bit k-1 of the word being built.
- R5: `rx_done` pulses for one cycle after the twelfth received bit. `word_out` takes the assembled word on that same edge and keeps its value at all other times.
- R6: When both mode pins are 1, no bit moves, the bit position is kept, no flag rises and `ser_oe` is 0.
- R7: When both mode pins are 0, the bit position returns to 0, so the next frame in either direction starts at bit 0.
- R8: `ser_oe` is 1 only in the cycle after an active transmit edge and is 0 in every other state. `ser_out` keeps its last value while `ser_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_mode | input | 1 | Requests transmit |
| rx_mode | input | 1 | Requests receive |
| word_in | input | 12 | Parallel word to transmit, held stable for the frame |
| word_out | output | 12 | Last fully received word |
| ser_in | input | 1 | Serial data from the wire |
| ser_out | output | 1 | Serial data to the wire |
| ser_oe | output | 1 | Output enable for the wire driver |
| tx_done | output | 1 | One-cycle pulse after twelve bits sent |
| rx_done | output | 1 | One-cycle pulse after twelve bits received |

## Verification
Every result is registered once, so each output reflects the inputs present at the previous rising edge. A transmitted bit, its enable, the completion flags and the received word all appear one edge after the stimulus that causes them. The bench applies inputs at the falling edge. It advances its behavioural model at the rising edge and compares all five outputs at the next falling edge, which is the first point where the registered result is settled. Frame-level checks count twelve active edges plus the single flag cycle. Gaps caused by both mode pins high or by an abort through idle are inserted on falling edges, so the expected bit position shifts by whole cycles only.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
  localparam int unsigned WORD_W = 12;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2,
    MODE_HOLD = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/sxr_bit_index.sv
module sxr_bit_index #(
  parameter int unsigned W  = 12,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          clr,
  output logic [IW-1:0] idx,
  output logic          at_last
);
  logic [IW-1:0] idx_q;

  assign idx     = idx_q;
  assign at_last = (idx_q == IW'(W-1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= at_last ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sxr_tx_path.sv
module sxr_tx_path #(
  parameter int unsigned W  = 12,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  word_in,
  output logic          ser_out,
  output logic          ser_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out <= 1'b0;
      ser_oe  <= 1'b0;
    end else begin
      ser_oe <= go;
      if (go) ser_out <= word_in[idx];
    end
  end
endmodule

// File: rtl/sxr_rx_path.sv
module sxr_rx_path #(
  parameter int unsigned W  = 12,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          last,
  input  logic [IW-1:0] idx,
  input  logic          ser_in,
  output logic [W-1:0]  word_out
);
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_nxt;

  always_comb begin
    acc_nxt      = acc_q;
    acc_nxt[idx] = ser_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      word_out <= '0;
    end else if (go) begin
      acc_q <= acc_nxt;
      if (last) word_out <= acc_nxt;
    end
  end
endmodule

// File: rtl/serial_xfer_reg.sv
module serial_xfer_reg
  import sxr_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_mode,
  input  logic         rx_mode,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out,
  input  logic         ser_in,
  output logic         ser_out,
  output logic         ser_oe,
  output logic         tx_done,
  output logic         rx_done
);
  xfer_mode_e    mode;
  logic          tx_go;
  logic          rx_go;
  logic [IW-1:0] idx;
  logic          at_last;

  // Mode pins are examined first, the completion flags second.
  always_comb begin
    unique case ({tx_mode, rx_mode})
      2'b10:   mode = tx_done ? MODE_HOLD : MODE_TX;
      2'b01:   mode = rx_done ? MODE_HOLD : MODE_RX;
      2'b00:   mode = MODE_IDLE;
      default: mode = MODE_HOLD;
    endcase
  end

  assign tx_go = (mode == MODE_TX);
  assign rx_go = (mode == MODE_RX);

  sxr_bit_index #(.W(W)) u_index (
    .clk     (clk),
    .rst     (rst),
    .adv     (tx_go | rx_go),
    .clr     (mode == MODE_IDLE),
    .idx     (idx),
    .at_last (at_last)
  );

  sxr_tx_path #(.W(W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .go      (tx_go),
    .idx     (idx),
    .word_in (word_in),
    .ser_out (ser_out),
    .ser_oe  (ser_oe)
  );

  sxr_rx_path #(.W(W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .go       (rx_go),
    .last     (at_last),
    .idx      (idx),
    .ser_in   (ser_in),
    .word_out (word_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      tx_done <= tx_go & at_last;
      rx_done <= rx_go & at_last;
    end
  end
endmodule

// File: rtl/serial_xfer_reg_chk.sv
module serial_xfer_reg_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         tx_mode,
  input logic         rx_mode,
  input logic [W-1:0] word_out,
  input logic         ser_out,
  input logic         ser_oe,
  input logic         tx_done,
  input logic         rx_done
);
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);  // R3
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);  // R5
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst)
    !(tx_done && rx_done));  // R3
  AST_OE_FROM_TX: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> $past(tx_mode && !rx_mode));  // R8
  AST_OUT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!ser_oe && !$past(rst)) |-> $stable(ser_out));  // R8
  AST_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!rx_done && !$past(rst)) |-> $stable(word_out));  // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_mode && rx_mode) |=> (!tx_done && !rx_done && !ser_oe));  // R6
endmodule

bind serial_xfer_reg serial_xfer_reg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_mode  (tx_mode),
  .rx_mode  (rx_mode),
  .word_out (word_out),
  .ser_out  (ser_out),
  .ser_oe   (ser_oe),
  .tx_done  (tx_done),
  .rx_done  (rx_done)
);

// File: tb/serial_xfer_reg_tb_top.sv
module serial_xfer_reg_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tx_mode = 1'b0;
  logic         rx_mode = 1'b0;
  logic [W-1:0] word_in = '0;
  logic [W-1:0] word_out;
  logic         ser_in = 1'b0;
  logic         ser_out;
  logic         ser_oe;
  logic         tx_done;
  logic         rx_done;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_xfer_reg dut_i (
    .clk      (clk),
    .rst      (rst),
    .tx_mode  (tx_mode),
    .rx_mode  (rx_mode),
    .word_in  (word_in),
    .word_out (word_out),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .ser_oe   (ser_oe),
    .tx_done  (tx_done),
    .rx_done  (rx_done)
  );

  // Behavioural reference: bit position as an integer, received bits in a queue.
  int       m_pos = 0;
  bit       m_txf = 0, m_rxf = 0, m_oe = 0, m_sout = 0;
  bit [W-1:0] m_word = '0;
  bit       rxq[$];

  always @(posedge clk) begin
    bit tx_ok, rx_ok, last;
    if (rst) begin
      m_pos = 0; m_txf = 0; m_rxf = 0; m_oe = 0; m_sout = 0; m_word = '0;
      rxq.delete();
    end else begin
      tx_ok = tx_mode && !rx_mode && !m_txf;
      rx_ok = !tx_mode && rx_mode && !m_rxf;
      last  = (m_pos == W-1);
      m_txf = tx_ok && last;
      m_rxf = rx_ok && last;
      m_oe  = tx_ok;
      if (tx_ok) m_sout = word_in[m_pos];
      if (rx_ok) begin
        rxq.push_back(ser_in);
        if (rxq.size() == W) begin
          for (int i = 0; i < W; i++) m_word[i] = rxq[i];
          rxq.delete();
        end
      end
      if (tx_ok || rx_ok) m_pos = last ? 0 : m_pos + 1;
      else if (!tx_mode && !rx_mode) begin
        m_pos = 0;
        rxq.delete();
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 tx_done", 32'(tx_done), 32'(m_txf));
    check("R5 rx_done", 32'(rx_done), 32'(m_rxf));
    check("R8 ser_oe", 32'(ser_oe), 32'(m_oe));
    check("R2 ser_out", 32'(ser_out), 32'(m_sout));
    check("R4 word_out", 32'(word_out), 32'(m_word));
  endtask

  // One cycle: compare the settled outputs, then drive the next inputs.
  task automatic cyc(bit t, bit r, bit s);
    @(negedge clk);
    compare_all();
    tx_mode = t; rx_mode = r; ser_in = s;
  endtask

  task automatic send_rx_word(logic [W-1:0] w);
    for (int i = 0; i < W; i++) cyc(0, 1, w[i]);
  endtask

  initial begin
    int pulses;
    logic [W-1:0] seen;
    logic [W-1:0] w;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 tx_done", 32'(tx_done), 0);
    check("R1 rx_done", 32'(rx_done), 0);
    check("R1 ser_oe", 32'(ser_oe), 0);
    check("R1 word_out", 32'(word_out), 0);
    rst = 1'b0;
    cyc(0, 0, 0);

    // R2 R3: one transmit frame, collect the bits explicitly
    word_in = 12'hA5C;
    cyc(1, 0, 0);
    pulses = 0; seen = '0;
    for (int i = 0; i < W; i++) begin
      cyc(1, 0, 0);
      seen[i] = ser_out;
      if (tx_done) pulses++;
    end
    check("R2 serial word", 32'(seen), 32'h0A5C);
    check("R3 flag at bit 11", 32'(tx_done), 1);
    cyc(1, 0, 0);
    check("R3 flag one cycle", 32'(tx_done), 0);
    check("R3 no transfer in flag cycle", 32'(ser_oe), 0);
    check("R3 single pulse", 32'(pulses), 1);
    cyc(1, 0, 0);
    check("R3 restart at bit 0", 32'(ser_out), 32'(word_in[0]));
    repeat (12) cyc(1, 0, 0);
    cyc(0, 0, 0);

    // R4 R5 R6: receive with both-high gaps inside the frame
    w = 12'h3C9;
    for (int i = 0; i < W; i++) begin
      cyc(0, 1, w[i]);
      if (i == 4) begin cyc(1, 1, 0); cyc(1, 1, 1); end
    end
    cyc(0, 0, 0);
    check("R5 rx_done pulse", 32'(rx_done), 1);
    check("R4 received word", 32'(word_out), 32'h3C9);
    cyc(0, 0, 0);
    check("R5 word kept", 32'(word_out), 32'h3C9);

    // R7: abort mid-frame through idle, then a full frame from bit 0
    for (int i = 0; i < 5; i++) cyc(0, 1, 1);
    cyc(0, 0, 0);
    send_rx_word(12'h0F1);
    cyc(0, 0, 0);
    check("R7 restart after idle", 32'(word_out), 32'h0F1);

    // R1: reset mid transmit
    word_in = 12'h777;
    for (int i = 0; i < 6; i++) cyc(1, 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 mid-frame oe", 32'(ser_oe), 0);
    check("R1 mid-frame word", 32'(word_out), 0);
    rst = 1'b0;
    cyc(0, 0, 0);

    // Mixed traffic against the model
    for (int n = 0; n < 30; n++) begin
      word_in = W'($urandom);
      if (n % 2 == 0) begin
        for (int i = 0; i < 14; i++) cyc(1, 0, 0);
      end else begin
        for (int i = 0; i < 14; i++) cyc($urandom_range(0, 7) == 0, 1, 1'($urandom));
      end
      cyc(0, 0, 0);
    end
    cyc(0, 0, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule